// File: doc/BRIEF.md
# Atomic Sequence Interrupt Lock

This block sits beside a processor pipeline and decides, cycle by cycle, which pending requests the core may accept. When the decoder meets a lock instruction it raises a lock request together with a length code that selects 1 to 4 following instructions. From that cycle until the last of those instructions has retired, the block holds off standard interrupts, peripheral data-transfer requests and class A traps. Class A traps are the non-maskable interrupt and stack overflow or underflow. Held-off requests are not cleared. They stay pending at the inputs and pass through again once the window closes.

The window is measured in retired instructions, not in clock cycles. An instruction that takes several cycles, or that is stretched by wait states, retires once and therefore counts once. Class B traps, which signal severe faults such as an illegal opcode or an illegal bus access, are never held off. When one is pending it is accepted, and the remaining lock count is discarded so that nothing of the aborted sequence stays masked.

Top module: `seq_lock_top`

## Requirements
- R1: After a synchronous active-low reset the lock flag is low and each acceptance enable equals its pending input.
- R2: In the cycle a lock request is present, the lock flag is high and the interrupt and transfer enables are low, whatever the pending inputs. There is no cycle of delay.
- R3: While the lock flag is high the class A trap enable is low.
- R4: The class B trap enable always equals the class B pending input, whether or not a lock is active.
- R5: A lock request with length code k (2-bit field, instruction count = k + 1) keeps the lock flag high until exactly k + 1 retire strobes have been seen after the request cycle. Cycles without a retire strobe do not count.
- R6: In the cycle after the edge that takes the last counted retire strobe, the lock flag is low and every pending request is enabled again.
- R7: A pending class B trap clears the lock counter at the next edge. This also applies when a lock request arrives in the same cycle, in which case the trap wins. With no new request, the lock flag is low in the following cycle.
- R8: A lock request made while a lock is active reloads the counter with the new count, which may lengthen or shorten the remaining window.
- R9: Retire strobes while no lock is active have no effect. Neither does a retire strobe in the same cycle as a lock request: it is not counted against the new window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_req | input | 1 | Lock instruction decoded this cycle |
| lock_len | input | 2 | Length code: count of locked instructions minus one |
| retire | input | 1 | One instruction completed this cycle |
| irq_pend | input | 1 | Standard interrupt request pending |
| xfer_pend | input | 1 | Peripheral transfer request pending |
| trap_a_pend | input | 1 | Class A trap pending |
| trap_b_pend | input | 1 | Class B trap pending |
| irq_en | output | 1 | Standard interrupt may be accepted |
| xfer_en | output | 1 | Peripheral transfer may be accepted |
| trap_a_en | output | 1 | Class A trap may be accepted |
| trap_b_en | output | 1 | Class B trap may be accepted |
| lock_active | output | 1 | Lock window in force |

## Verification
The enables and the lock flag are combinational in the current inputs and the count register. A lock request or a class B trap therefore shows on the outputs in its own cycle. A counter change caused by a retire strobe, a reload or an abort shows in the cycle after the edge that takes it. The bench applies each vector after a falling edge and samples one time unit later, before the next rising edge. In this way it checks the immediate effects in the stimulus cycle and the counted effects in the vector that follows.

// File: rtl/seq_lock_pkg.sv
// Package: shared sizing and request-source description for the lock block.
// Assumes at most a few instructions per lock window; sizes derive from MAX_LEN.
package seq_lock_pkg;
    // Longest lock window in instructions.
    localparam int MAX_LEN = 4;
    // Width of the length code (count minus one).
    localparam int LEN_W   = $clog2(MAX_LEN);
    // Width of the remaining-instruction counter (holds 0..MAX_LEN).
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    // Request sources in the order the gating vector uses.
    typedef enum logic [1:0] {
        SRC_IRQ    = 2'd0,
        SRC_XFER   = 2'd1,
        SRC_TRAP_A = 2'd2,
        SRC_TRAP_B = 2'd3
    } src_e;

    localparam int NUM_SRC = 4;
    // One bit per source: set when the lock window holds it off.
    localparam logic [NUM_SRC-1:0] MASKABLE = 4'b0111;
endpackage

// File: rtl/seq_lock_counter.sv
// Module: remaining-instruction counter for the lock window.
// Does: loads count+1 on a lock request, steps down once per retire strobe,
// and clears on an abort. Assumes retire pulses once per completed
// instruction, however many cycles that instruction took.
module seq_lock_counter #(
    parameter int LEN_W = seq_lock_pkg::LEN_W,
    parameter int CNT_W = seq_lock_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] len_code,
    input  logic             step,
    input  logic             abort,
    output logic             busy
);
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] load_val;

    // Convert the length code to an instruction count.
    always_comb begin
        load_val = CNT_W'(len_code) + CNT_W'(1);
    end

    // Counter update: abort beats load, load beats step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (abort) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (step && (remain_q != '0)) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    // Window is open while instructions remain.
    always_comb begin
        busy = (remain_q != '0);
    end
endmodule

// File: rtl/seq_lock_gate.sv
// Module: per-source acceptance gating.
// Does: passes each pending request through, except that a source marked in
// MASK_SEL is blocked while inhibit is high. Assumes inhibit is already
// combined from the live request and the registered window.
module seq_lock_gate #(
    parameter int                 N        = seq_lock_pkg::NUM_SRC,
    parameter logic [N-1:0]       MASK_SEL = seq_lock_pkg::MASKABLE
) (
    input  logic         inhibit,
    input  logic [N-1:0] pend,
    output logic [N-1:0] accept
);
    for (genvar i = 0; i < N; i++) begin : g_src
        if (MASK_SEL[i]) begin : g_masked
            // Maskable source: blocked during the window.
            always_comb accept[i] = pend[i] & ~inhibit;
        end else begin : g_pass
            // Severe-fault source: never blocked.
            always_comb accept[i] = pend[i];
        end
    end
endmodule

// File: rtl/seq_lock_top.sv
// Module: atomic-sequence interrupt lock, top level.
// Does: opens a lock window of 1..MAX_LEN retired instructions on a lock
// request, gates interrupt, transfer and class A trap acceptance during it,
// and always lets class B traps through. A pending class B trap aborts the
// window. Assumes pending lines are held by their sources until accepted.
module seq_lock_top
    import seq_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock_req,
    input  logic [LEN_W-1:0] lock_len,
    input  logic             retire,
    input  logic             irq_pend,
    input  logic             xfer_pend,
    input  logic             trap_a_pend,
    input  logic             trap_b_pend,
    output logic             irq_en,
    output logic             xfer_en,
    output logic             trap_a_en,
    output logic             trap_b_en,
    output logic             lock_active
);
    logic               window_busy;
    logic               inhibit;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] accept_vec;

    seq_lock_counter #(
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_req),
        .len_code (lock_len),
        .step     (retire),
        .abort    (trap_b_pend),
        .busy     (window_busy)
    );

    // Inhibit starts in the request cycle itself.
    always_comb begin
        inhibit = lock_req | window_busy;
    end

    // Pack the sources in package order.
    always_comb begin
        pend_vec              = '0;
        pend_vec[SRC_IRQ]    = irq_pend;
        pend_vec[SRC_XFER]   = xfer_pend;
        pend_vec[SRC_TRAP_A] = trap_a_pend;
        pend_vec[SRC_TRAP_B] = trap_b_pend;
    end

    seq_lock_gate #(
        .N        (NUM_SRC),
        .MASK_SEL (MASKABLE)
    ) u_gate (
        .inhibit (inhibit),
        .pend    (pend_vec),
        .accept  (accept_vec)
    );

    // Unpack the acceptance enables and drive the status flag.
    always_comb begin
        irq_en      = accept_vec[SRC_IRQ];
        xfer_en     = accept_vec[SRC_XFER];
        trap_a_en   = accept_vec[SRC_TRAP_A];
        trap_b_en   = accept_vec[SRC_TRAP_B];
        lock_active = inhibit;
    end
endmodule

// File: rtl/seq_lock_chk.sv
// Module: property checker for seq_lock_top, attached by bind below.
// Observes ports only.
module seq_lock_chk (
    input logic clk,
    input logic rst_n,
    input logic lock_req,
    input logic retire,
    input logic irq_pend,
    input logic xfer_pend,
    input logic trap_a_pend,
    input logic trap_b_pend,
    input logic irq_en,
    input logic xfer_en,
    input logic trap_a_en,
    input logic trap_b_en,
    input logic lock_active
);
    // R1
    idle_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_active |-> (irq_en == irq_pend) && (xfer_en == xfer_pend) && (trap_a_en == trap_a_pend));

    // R2
    req_masks_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |-> lock_active && !irq_en && !xfer_en);

    // R3
    trap_a_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_active |-> !trap_a_en);

    // R4
    trap_b_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_b_en == trap_b_pend);

    // R7
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_b_pend |=> (!lock_active || lock_req));

    // R9
    idle_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_active && !lock_req) |=> (!lock_active || lock_req));
endmodule

bind seq_lock_top seq_lock_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_req    (lock_req),
    .retire      (retire),
    .irq_pend    (irq_pend),
    .xfer_pend   (xfer_pend),
    .trap_a_pend (trap_a_pend),
    .trap_b_pend (trap_b_pend),
    .irq_en      (irq_en),
    .xfer_en     (xfer_en),
    .trap_a_en   (trap_a_en),
    .trap_b_en   (trap_b_en),
    .lock_active (lock_active)
);

// File: tb/seq_lock_top_test.sv
module seq_lock_top_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       lock_req;
    logic [1:0] lock_len;
    logic       retire;
    logic       irq_pend, xfer_pend, trap_a_pend, trap_b_pend;
    logic       irq_en, xfer_en, trap_a_en, trap_b_en, lock_active;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    seq_lock_top uut (
        .clk (clk), .rst_n (rst_n),
        .lock_req (lock_req), .lock_len (lock_len), .retire (retire),
        .irq_pend (irq_pend), .xfer_pend (xfer_pend),
        .trap_a_pend (trap_a_pend), .trap_b_pend (trap_b_pend),
        .irq_en (irq_en), .xfer_en (xfer_en),
        .trap_a_en (trap_a_en), .trap_b_en (trap_b_en),
        .lock_active (lock_active)
    );

    // Vector: [12] req [11:10] len [9] retire [8:5] irq,xfer,trapA,trapB pending
    //         [4] expected lock flag [3:0] expected irq,xfer,trapA,trapB enables
    localparam int NV = 26;
    localparam logic [12:0] VEC [NV] = '{
        13'b0_00_0_1110_0_1110, // 0  R1 idle, requests pass
        13'b0_00_1_1110_0_1110, // 1  R9 retire while idle
        13'b1_10_1_1110_1_0000, // 2  R2 lock of 3, same-cycle retire ignored
        13'b0_00_0_1110_1_0000, // 3  R5 no retire: 3 left
        13'b0_00_1_1110_1_0000, // 4  R5 retire 3->2
        13'b0_00_0_1110_1_0000, // 5  R5 long instruction: still 2
        13'b0_00_1_1110_1_0000, // 6  R3 retire 2->1
        13'b0_00_1_1110_1_0000, // 7  R5 last retire 1->0
        13'b0_00_0_1110_0_1110, // 8  R6 released, held requests pass
        13'b1_00_0_1111_1_0001, // 9  R4 trap B beside lock request
        13'b0_00_0_1110_0_1110, // 10 R7 trap B won over request
        13'b1_11_0_1110_1_0000, // 11 R8 lock of 4
        13'b0_00_1_1110_1_0000, // 12 R8 4->3
        13'b1_00_0_1110_1_0000, // 13 R8 reload to 1
        13'b0_00_1_1110_1_0000, // 14 R8 1->0
        13'b0_00_0_1110_0_1110, // 15 R8 shortened window done
        13'b1_01_0_1110_1_0000, // 16 R2 lock of 2
        13'b0_00_0_1111_1_0001, // 17 R4 trap B inside window
        13'b0_00_0_1110_0_1110, // 18 R7 aborted window
        13'b1_11_1_1110_1_0000, // 19 R5 lock of 4
        13'b0_00_1_1110_1_0000, // 20 R5 4->3
        13'b0_00_1_1110_1_0000, // 21 R5 3->2
        13'b0_00_1_1110_1_0000, // 22 R5 2->1
        13'b0_00_1_1110_1_0000, // 23 R5 1->0
        13'b0_00_0_1110_0_1110, // 24 R6 release after four
        13'b0_00_0_0000_0_0000  // 25 R1 nothing pending
    };
    localparam int TAG [NV] = '{1,9,2,5,5,5,3,5,6,4,7,8,8,8,8,8,2,4,7,5,5,5,5,5,6,1};

    task automatic apply(input logic [12:0] v);
        lock_req    = v[12];
        lock_len    = v[11:10];
        retire      = v[9];
        irq_pend    = v[8];
        xfer_pend   = v[7];
        trap_a_pend = v[6];
        trap_b_pend = v[5];
    endtask

    task automatic check(input int tag, input logic [4:0] exp);
        logic [4:0] got;
        got = {lock_active, irq_en, xfer_en, trap_a_en, trap_b_en};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d: flag/enables got %b expected %b", tag, got, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        apply(13'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            #1;
            check(TAG[i], VEC[i][4:0]);
            @(negedge clk);
        end
        // R1: reset in the middle of a window clears it.
        apply(13'b1_11_0_1110_0_0000);
        @(negedge clk);
        apply(13'b0_00_0_1110_0_0000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(1, 5'b0_1110);
        // R9: retire strobes after reset open nothing.
        @(negedge clk);
        apply(13'b0_00_1_1110_0_0000);
        @(negedge clk);
        #1;
        check(9, 5'b0_1110);
        // R3: class A alone held off during a window of 1, released after.
        @(negedge clk);
        apply(13'b1_00_0_0010_0_0000);
        #1;
        check(3, 5'b1_0000);
        @(negedge clk);
        apply(13'b0_00_1_0010_0_0000);
        #1;
        check(3, 5'b1_0000);
        @(negedge clk);
        apply(13'b0_00_0_0010_0_0000);
        #1;
        check(6, 5'b0_0010);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule